// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block finds the vertical sync interval in a stream of digitized composite video samples and produces a vertical sync pulse and an odd/even field flag. An upstream slicer supplies one bit per sample that is high while the signal sits at sync-tip level, plus a strobe marking the first sample of each line. Within every line the block totals the sync-tip samples. When that total climbs past a programmable threshold (which only the long broad pulses of the vertical interval can do), a new field begins. The field flag is taken from the half of the line in which the crossing happened.

When no vertical interval is seen, the block keeps its outputs alive by generating field starts on its own. It counts half-lines and opens a new field every 525 half-lines for the 60 Hz standard or every 625 half-lines for the 50 Hz standard. Because both counts are odd, the generated fields alternate between starting at a line boundary and starting at mid-line. A separate line counter watches for a long stretch with no detected vertical interval. It then emits a single-cycle pulse that asks the phase-locked loops to return to acquisition.

Top module: `vsync_field_det`

## Requirements
- R1: While reset is held, and right after it, `vsync`, `field` and `reinit` are all 0.
- R2: The low count is the number of samples with `sync_low`=1 since the most recent `line_start`, including the strobe sample itself. Separate low stretches in one line add up, and the count restarts at every line start. It saturates at its maximum instead of wrapping.
- R3: `vsync` rises on the clock edge that captures the sample whose low count first becomes strictly greater than `vdet_thresh`. A count equal to the threshold does not detect, and short horizontal sync pulses alone never do.
- R4: On a detected field start, `field` becomes 0 if the sample index within the line is below HALF_LINE and 1 otherwise. The index is 0 at `line_start`. `field` changes only on an edge where `vsync` rises.
- R5: Half-line boundaries are the `line_start` sample and the sample at index HALF_LINE. `vsync` falls on the edge of the VS_HALF-th boundary after the one on which it rose, where VS_HALF defaults to 13, giving about 6.5 lines.
- R6: While `vsync` is high, further threshold crossings are ignored. They do not lengthen the pulse, change `field`, or restart the loss counter.
- R7: If VS_HALF... no field start has occurred for a full field of half-line boundaries, `vsync` rises on that boundary and `field` toggles. A full field is 525 half-lines with `std_pal`=0 and 625 half-lines with `std_pal`=1.
- R8: `reinit` is a one-cycle pulse on the edge of the `line_start` that makes the count of lines since the last detected field start reach LOSS_LINES+MISS_LINES (337+3). The count then restarts. Detected field starts clear it, but generated field starts do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | High for the first sample of each line |
| sync_low | input | 1 | High while the current sample is at sync-tip level |
| vdet_thresh | input | LOW_W | Low-count threshold for vertical detection |
| std_pal | input | 1 | 0 selects 525 half-line fields, 1 selects 625 |
| vsync | output | 1 | Vertical sync pulse |
| field | output | 1 | 0 for odd field, 1 for even field |
| reinit | output | 1 | One-cycle request to reinitialize the loops |

## Verification
All three outputs are registered, so each result appears one edge after the sample that causes it. A detection shows up after the crossing sample, a falling `vsync` after the VS_HALF-th boundary sample, a generated field start after the boundary sample that completes the field, and `reinit` after the qualifying `line_start` sample. The bench drives one sample per falling edge and reads the outputs at the next falling edge, before the following sample is driven. It then tags every output change with the line and index of the sample just captured. It compares those tags with positions worked out arithmetically, such as half-line position 2L+h plus 13, 525 or 625 for pulse end and generated starts, and line L+340 for loss.

// File: rtl/vsync_field_det.sv
module vsync_field_det #(
  parameter int POS_W       = 11,
  parameter int HALF_LINE   = 429,
  parameter int LOW_W       = 8,
  parameter int VS_HALF     = 13,
  parameter int NTSC_HALVES = 525,
  parameter int PAL_HALVES  = 625,
  parameter int LOSS_LINES  = 337,
  parameter int MISS_LINES  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             sync_low,
  input  logic [LOW_W-1:0] vdet_thresh,
  input  logic             std_pal,
  output logic             vsync,
  output logic             field,
  output logic             reinit
);

  localparam int LOSS_TOTAL = LOSS_LINES + MISS_LINES;
  localparam int LC_W       = $clog2(LOSS_TOTAL + 1);
  localparam int MAX_HALVES = (NTSC_HALVES > PAL_HALVES) ? NTSC_HALVES : PAL_HALVES;
  localparam int HC_W       = $clog2(MAX_HALVES + 1);
  localparam int VC_W       = $clog2(VS_HALF + 1);

  logic [POS_W-1:0] pos_q, idx;
  logic [LOW_W-1:0] low_q, low_d;
  logic [HC_W-1:0]  half_q, fld_len;
  logic [LC_W-1:0]  line_q;
  logic [VC_W-1:0]  vs_left;
  logic             mid_tick, half_tick, det, free_start;

  assign idx       = line_start ? '0 : ((&pos_q) ? pos_q : pos_q + 1'b1);
  assign mid_tick  = !line_start && (idx == POS_W'(HALF_LINE));
  assign half_tick = line_start || mid_tick;

  assign low_d = line_start ? LOW_W'(sync_low)
               : (sync_low && !(&low_q)) ? low_q + 1'b1 : low_q;

  assign det = !vsync && (low_d > vdet_thresh) &&
               (line_start || (low_q <= vdet_thresh));

  assign fld_len    = std_pal ? HC_W'(PAL_HALVES) : HC_W'(NTSC_HALVES);
  assign free_start = !vsync && !det && half_tick &&
                      (({1'b0, half_q} + 1'b1) >= {1'b0, fld_len});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      low_q   <= '0;
      half_q  <= '0;
      line_q  <= '0;
      vs_left <= '0;
      vsync   <= 1'b0;
      field   <= 1'b0;
      reinit  <= 1'b0;
    end else begin
      pos_q  <= idx;
      low_q  <= low_d;
      reinit <= 1'b0;

      if (det || free_start) begin
        vsync   <= 1'b1;
        vs_left <= VC_W'(VS_HALF);
        half_q  <= '0;
        field   <= det ? (idx >= POS_W'(HALF_LINE)) : ~field;
      end else begin
        if (half_tick && !(&half_q))
          half_q <= half_q + 1'b1;
        if (vsync && half_tick) begin
          vs_left <= vs_left - 1'b1;
          if (vs_left == VC_W'(1))
            vsync <= 1'b0;
        end
      end

      if (det)
        line_q <= '0;
      else if (line_start) begin
        if (line_q + 1'b1 == LC_W'(LOSS_TOTAL)) begin
          reinit <= 1'b1;
          line_q <= '0;
        end else
          line_q <= line_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/vfd_checker.sv
module vfd_checker #(
  parameter int LOW_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_start,
  input logic             sync_low,
  input logic             mid_tick,
  input logic [LOW_W-1:0] low_q,
  input logic             vsync,
  input logic             field,
  input logic             reinit
);

  AST_LOW_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> (low_q >= $past(low_q))); // R2

  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> $past(sync_low || line_start || mid_tick)); // R3

  AST_FIELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (field != $past(field)) |-> $rose(vsync)); // R4

  AST_FALL_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync) |-> $past(line_start || mid_tick)); // R5

  AST_REINIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> !reinit); // R8

  AST_REINIT_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |-> $past(line_start)); // R8

endmodule

bind vsync_field_det vfd_checker #(.LOW_W(LOW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .sync_low(sync_low),
  .mid_tick(mid_tick), .low_q(low_q), .vsync(vsync), .field(field),
  .reinit(reinit)
);

// File: tb/vsync_field_det_tb_top.sv
module vsync_field_det_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINE  = 32;
  localparam int HALF  = 16;
  localparam int LOW_W = 8;
  localparam int T     = 8;
  localparam int HSW   = 3;

  logic clk = 1'b0, rst_n = 1'b0, line_start = 1'b0, sync_low = 1'b0, std_pal = 1'b0;
  logic [LOW_W-1:0] thresh = LOW_W'(T);
  logic vsync, field, reinit;

  int n_vec = 0, n_bad = 0;
  int ln = 0, cur_line = 0, cur_idx = 0;
  int prev_vs = 0, prev_ri = 0;
  int n_rise = 0, n_fall = 0, n_ri = 0, ri_wide = 0;
  int rise_l[4], rise_i[4], rise_f[4];
  int fall_l = 0, fall_i = 0, ri_l = 0, ri_i = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsync_field_det #(.HALF_LINE(HALF), .LOW_W(LOW_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .sync_low(sync_low),
    .vdet_thresh(thresh), .std_pal(std_pal), .vsync(vsync), .field(field),
    .reinit(reinit)
  );

  task automatic check(string tag, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic observe();
    if (vsync && prev_vs == 0) begin
      if (n_rise < 4) begin
        rise_l[n_rise] = cur_line; rise_i[n_rise] = cur_idx; rise_f[n_rise] = int'(field);
      end
      n_rise++;
    end
    if (!vsync && prev_vs == 1) begin
      n_fall++; fall_l = cur_line; fall_i = cur_idx;
    end
    if (reinit) begin
      if (prev_ri == 1) ri_wide++;
      else begin n_ri++; ri_l = cur_line; ri_i = cur_idx; end
    end
    prev_vs = int'(vsync);
    prev_ri = int'(reinit);
  endtask

  task automatic run_line(int a0, int a1, int b0, int b1);
    for (int i = 0; i < LINE; i++) begin
      @(negedge clk);
      observe();
      cur_line   = ln;
      cur_idx    = i;
      line_start = (i == 0);
      sync_low   = (i < HSW) || (i >= a0 && i < a1) || (i >= b0 && i < b1);
    end
    ln++;
  endtask

  task automatic plain(int n);
    repeat (n) run_line(0, 0, 0, 0);
  endtask

  task automatic clear_log();
    n_rise = 0; n_fall = 0; n_ri = 0; ri_wide = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int base, h;
    repeat (3) @(negedge clk);
    check("R1 vsync in reset", int'(vsync), 0);
    check("R1 field in reset", int'(field), 0);
    check("R1 reinit in reset", int'(reinit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 vsync after reset", int'(vsync), 0);

    plain(4);
    check("R3 hsync-only lines detect nothing", n_rise, 0);

    clear_log();
    base = ln;
    run_line(HSW, 20, 0, 0);
    plain(2);
    run_line(HSW, 30, 0, 0);
    plain(6);
    check("R3 one detection", n_rise, 1);
    check("R3 detection line", rise_l[0], base);
    check("R3 detection index", rise_i[0], HSW + (T + 1 - HSW) - 1);
    check("R4 field odd (first half)", rise_f[0], 0);
    h = 2 * base + 13;
    check("R5 single fall", n_fall, 1);
    check("R5 fall line", fall_l, h / 2);
    check("R5 fall index", fall_i, (h % 2) * HALF);
    check("R6 field kept after ignored crossing", int'(field), 0);

    clear_log();
    run_line(HSW, HSW + T - HSW, 0, 0);
    plain(1);
    check("R3 count equal to threshold", n_rise, 0);

    clear_log();
    run_line(LINE - (T - HSW), LINE, 0, 0);
    run_line(HSW, HSW + T - HSW, 0, 0);
    plain(1);
    check("R2 count restarts at line start", n_rise, 0);

    clear_log();
    run_line(10, 13, 20, 22);
    plain(1);
    check("R2 split stretches totalling threshold", n_rise, 0);

    clear_log();
    base = ln;
    run_line(10, 13, 20, 23);
    plain(8);
    check("R2 split stretches accumulate", n_rise, 1);
    check("R2 detection index", rise_i[0], 22);
    check("R4 field even (second half)", rise_f[0], 1);
    h = 2 * base + 1 + 13;
    check("R5 fall line (mid start)", fall_l, h / 2);
    check("R5 fall index (mid start)", fall_i, (h % 2) * HALF);

    clear_log();
    while (ln < base + 536) plain(1);
    h = 2 * base + 1 + 525;
    check("R7 two generated starts", n_rise, 2);
    check("R7 first generated line", rise_l[0], h / 2);
    check("R7 first generated index", rise_i[0], (h % 2) * HALF);
    check("R7 first generated field", rise_f[0], 0);
    h = h + 525;
    check("R7 second generated line", rise_l[1], h / 2);
    check("R7 second generated index", rise_i[1], (h % 2) * HALF);
    check("R7 second generated field", rise_f[1], 1);
    check("R8 one reinit", n_ri, 1);
    check("R8 reinit line", ri_l, base + 340);
    check("R8 reinit index", ri_i, 0);
    check("R8 reinit width", ri_wide, 0);

    clear_log();
    std_pal = 1'b1;
    base = ln;
    run_line(HSW, 20, 0, 0);
    while (ln < base + 345) plain(1);
    h = 2 * base + 625;
    check("R7 PAL detect plus one generated", n_rise, 2);
    check("R7 PAL generated line", rise_l[1], h / 2);
    check("R7 PAL generated index", rise_i[1], (h % 2) * HALF);
    check("R7 PAL generated field toggles", rise_f[1], 1);
    check("R8 detection restarts loss count", n_ri, 1);
    check("R8 reinit line after detection", ri_l, base + 340);
    check("R8 reinit width after detection", ri_wide, 0);

    summary();
    $finish;
  end
endmodule